// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Read Responder

This block stands in for a small three-wire serial EEPROM that a host reaches through a bit-banged control register. The host writes select, serial clock and data-in levels into a four-bit register and reads the same register back to see the data-out bit. The block watches those levels. It recognises a start bit, a two-bit opcode and a six-bit word address, then shifts a sixteen-bit word out on data-out, one bit per serial clock rising edge.

The readable contents are derived from a 48-bit station address on an input port. Its three sixteen-bit halves sit at fixed word locations, and every other location is treated as absent. The read command is the only one decoded. Any other opcode, or an address outside the mapped words, raises an error output and drops the exchange.

Top module: `uwire_eeprom_rd`

## Requirements
- R1: After reset, the host register reads 0 (all four bits), and both data_out and err are 0.
- R2: The protocol advances only on a serial clock rising edge (sclk bit 0 on one cycle, 1 on the next) while select is 1. Falling edges, repeated writes of sclk=1, and data-in changes without a rising edge leave data-out unchanged.
- R3: While select is 0 the exchange returns to idle, err is cleared and the data-in bit reads back 0 even when written as 1. A fresh read after an aborted one returns correct data.
- R4: In idle, rising edges with data-in 0 are ignored. The first rising edge with data-in 1 is the start bit.
- R5: The two opcode bits are taken MSB first. Only binary 10 continues. Any other value (00, 01, 11) sets err, which stays at 1 until select goes to 0, and the block returns to idle without changing data-out.
- R6: The six address bits are taken MSB first. With byte k of station_addr defined as bits [8k+7:8k], word 0x0A returns {byte5, byte4}, word 0x0B returns {byte3, byte2} and word 0x0C returns {byte1, byte0}.
- R7: Any other address (for example 0x00, 0x09, 0x0D or 0x3F) sets err and returns to idle without changing data-out.
- R8: After a mapped address, each of the next 16 rising edges places the next word bit on data-out, MSB first. After the 16th bit the block is idle again, so a further edge with data-in 0 changes nothing and a new start bit begins a new read without deselecting.
- R9: When the last address bit of a mapped address is taken, the data-in bit of the host register is cleared to 0.
- R10: The host register bit positions are: bit 0 data-in, bit 1 serial clock, bit 2 select, bit 3 data-out. A host write never changes bit 3, whatever value it carries there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe for the control register |
| host_wdata | input | 4 | Host write value: bit 0 data-in, bit 1 serial clock, bit 2 select, bit 3 ignored |
| station_addr | input | 48 | Station address that supplies the three readable words |
| host_rdata | output | 4 | Control register readback, bit 3 is data-out |
| data_out | output | 1 | Serial data-out level |
| err | output | 1 | Unsupported opcode or unmapped address seen since select rose |

## Verification
The bench builds the block with its default parameters: six address bits, sixteen data bits, a two-bit opcode and the three words starting at location 0x0A. The station address has six distinct, asymmetric bytes, so a swapped byte, a swapped word or a reversed bit order shows up in the returned data. The six-bit address width lets the bench drive the extreme locations 0x00 and 0x3F next to the immediate neighbours 0x09 and 0x0D of the mapped window.

// File: rtl/uwr_pkg.sv
package uwr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_OPC  = 2'd1,
    ST_ADDR = 2'd2,
    ST_DATA = 2'd3
  } uwr_state_e;

  localparam int HR_DIN  = 0;
  localparam int HR_SCLK = 1;
  localparam int HR_SEL  = 2;
  localparam int HR_DOUT = 3;
  localparam int HR_W    = 4;
endpackage

// File: rtl/uwr_host_reg.sv
module uwr_host_reg
  import uwr_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [HR_W-1:0] wdata,
  input  logic            dout_ld,
  input  logic            dout_val,
  input  logic            din_clr,
  output logic            sel,
  output logic            sclk,
  output logic            din,
  output logic            dout,
  output logic [HR_W-1:0] rdata
);
  logic sel_q, sclk_q, din_q, dout_q;
  logic sel_nx, sclk_nx, din_nx, dout_nx;

  always_comb begin
    sel_nx  = we ? wdata[HR_SEL]  : sel_q;
    sclk_nx = we ? wdata[HR_SCLK] : sclk_q;
    if (!sel_nx)      din_nx = 1'b0;
    else if (we)      din_nx = wdata[HR_DIN];
    else if (din_clr) din_nx = 1'b0;
    else              din_nx = din_q;
    dout_nx = dout_ld ? dout_val : dout_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= 1'b0;
      sclk_q <= 1'b0;
      din_q  <= 1'b0;
      dout_q <= 1'b0;
    end else begin
      sel_q  <= sel_nx;
      sclk_q <= sclk_nx;
      din_q  <= din_nx;
      dout_q <= dout_nx;
    end
  end

  assign sel  = sel_q;
  assign sclk = sclk_q;
  assign din  = din_q;
  assign dout = dout_q;

  always_comb begin
    rdata          = '0;
    rdata[HR_DIN]  = din_q;
    rdata[HR_SCLK] = sclk_q;
    rdata[HR_SEL]  = sel_q;
    rdata[HR_DOUT] = dout_q;
  end
endmodule

// File: rtl/uwr_edge.sv
module uwr_edge (
  input  logic clk,
  input  logic rst,
  input  logic sel,
  input  logic sclk,
  output logic rise
);
  logic sclk_prev;

  always_ff @(posedge clk) begin
    if (rst) sclk_prev <= 1'b0;
    else     sclk_prev <= sclk;
  end

  assign rise = sel & sclk & ~sclk_prev;
endmodule

// File: rtl/uwr_wordmap.sv
module uwr_wordmap #(
  parameter int ADDR_BITS = 6,
  parameter int DATA_BITS = 16,
  parameter int DEPTH     = 64,
  parameter int NWORDS    = 3,
  parameter int BASE_WORD = 10
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [ADDR_BITS-1:0]        addr,
  input  logic [NWORDS*DATA_BITS-1:0] station_addr,
  output logic                        hit,
  output logic [DATA_BITS-1:0]        word
);
  localparam int SA_BITS = NWORDS * DATA_BITS;

  logic                 in_range;
  logic [NWORDS-1:0]    hit_vec;
  logic [DATA_BITS-1:0] masked [NWORDS];

  assign in_range = (32'(addr) < DEPTH);

  // Word i holds the i-th sixteen-bit slice counted from the top byte down.
  for (genvar i = 0; i < NWORDS; i++) begin : g_word
    assign hit_vec[i] = in_range && (addr == ADDR_BITS'(BASE_WORD + i));
    assign masked[i]  = hit_vec[i] ? station_addr[SA_BITS-1-i*DATA_BITS -: DATA_BITS]
                                   : '0;
  end

  always_comb begin
    word = '0;
    for (int i = 0; i < NWORDS; i++) word = word | masked[i];
  end

  assign hit = |hit_vec;

  // R6
  map_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));
endmodule

// File: rtl/uwr_fsm.sv
module uwr_fsm
  import uwr_pkg::*;
#(
  parameter int OPC_BITS  = 2,
  parameter int ADDR_BITS = 6,
  parameter int DATA_BITS = 16,
  parameter int READ_OPC  = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sel,
  input  logic                 rise,
  input  logic                 din,
  input  logic                 map_hit,
  input  logic [DATA_BITS-1:0] map_word,
  output logic [ADDR_BITS-1:0] look_addr,
  output logic                 dout_ld,
  output logic                 dout_val,
  output logic                 din_clr,
  output logic                 err
);
  localparam int MAXB  = (DATA_BITS > ADDR_BITS) ?
                         ((DATA_BITS > OPC_BITS) ? DATA_BITS : OPC_BITS) :
                         ((ADDR_BITS > OPC_BITS) ? ADDR_BITS : OPC_BITS);
  localparam int CNT_W = $clog2(MAXB + 1);

  uwr_state_e           state_q, state_nx;
  logic [CNT_W-1:0]     cnt_q, cnt_nx;
  logic [OPC_BITS-1:0]  opc_q, opc_nx, opc_sh;
  logic [ADDR_BITS-1:0] addr_q, addr_nx, addr_sh;
  logic [DATA_BITS-1:0] data_q, data_nx;
  logic                 err_q, err_nx;
  logic                 last;

  assign opc_sh    = {opc_q[OPC_BITS-2:0], din};
  assign addr_sh   = {addr_q[ADDR_BITS-2:0], din};
  assign look_addr = addr_sh;
  assign last      = (cnt_q == CNT_W'(1));
  assign dout_val  = data_q[DATA_BITS-1];

  always_comb begin
    state_nx = state_q;
    cnt_nx   = cnt_q;
    opc_nx   = opc_q;
    addr_nx  = addr_q;
    data_nx  = data_q;
    err_nx   = err_q;
    dout_ld  = 1'b0;
    din_clr  = 1'b0;
    if (!sel) begin
      state_nx = ST_IDLE;
      cnt_nx   = '0;
      opc_nx   = '0;
      addr_nx  = '0;
      err_nx   = 1'b0;
    end else if (rise) begin
      unique case (state_q)
        ST_IDLE: if (din) begin
          state_nx = ST_OPC;
          cnt_nx   = CNT_W'(OPC_BITS);
          opc_nx   = '0;
        end
        ST_OPC: begin
          opc_nx = opc_sh;
          cnt_nx = cnt_q - CNT_W'(1);
          if (last) begin
            if (opc_sh == OPC_BITS'(READ_OPC)) begin
              state_nx = ST_ADDR;
              cnt_nx   = CNT_W'(ADDR_BITS);
              addr_nx  = '0;
            end else begin
              state_nx = ST_IDLE;
              cnt_nx   = '0;
              err_nx   = 1'b1;
            end
          end
        end
        ST_ADDR: begin
          addr_nx = addr_sh;
          cnt_nx  = cnt_q - CNT_W'(1);
          if (last) begin
            if (map_hit) begin
              state_nx = ST_DATA;
              cnt_nx   = CNT_W'(DATA_BITS);
              data_nx  = map_word;
              din_clr  = 1'b1;
            end else begin
              state_nx = ST_IDLE;
              cnt_nx   = '0;
              err_nx   = 1'b1;
            end
          end
        end
        ST_DATA: begin
          dout_ld = 1'b1;
          data_nx = data_q << 1;
          cnt_nx  = cnt_q - CNT_W'(1);
          if (last) state_nx = ST_IDLE;
        end
        default: state_nx = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      opc_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_nx;
      cnt_q   <= cnt_nx;
      opc_q   <= opc_nx;
      addr_q  <= addr_nx;
      data_q  <= data_nx;
      err_q   <= err_nx;
    end
  end

  assign err = err_q;

  // R2
  no_rise_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (sel && !rise) |=> ($stable(state_q) && $stable(cnt_q)));
  // R3
  deselect_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !sel |=> (state_q == ST_IDLE && !err_q));
  // R5
  err_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(err_q) |-> ($past(state_q) == ST_OPC || $past(state_q) == ST_ADDR));
  // R8
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    32'(cnt_q) <= MAXB);
endmodule

// File: rtl/uwire_eeprom_rd.sv
module uwire_eeprom_rd
  import uwr_pkg::*;
#(
  parameter int OPC_BITS  = 2,
  parameter int ADDR_BITS = 6,
  parameter int DATA_BITS = 16,
  parameter int DEPTH     = 64,
  parameter int NWORDS    = 3,
  parameter int BASE_WORD = 10,
  parameter int READ_OPC  = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        host_we,
  input  logic [3:0]                  host_wdata,
  input  logic [NWORDS*DATA_BITS-1:0] station_addr,
  output logic [3:0]                  host_rdata,
  output logic                        data_out,
  output logic                        err
);
  logic                 sel, sclk, din, dout, rise;
  logic                 dout_ld, dout_val, din_clr, map_hit;
  logic [ADDR_BITS-1:0] look_addr;
  logic [DATA_BITS-1:0] map_word;

  uwr_host_reg u_reg (
    .clk(clk), .rst(rst), .we(host_we), .wdata(host_wdata),
    .dout_ld(dout_ld), .dout_val(dout_val), .din_clr(din_clr),
    .sel(sel), .sclk(sclk), .din(din), .dout(dout), .rdata(host_rdata)
  );

  uwr_edge u_edge (
    .clk(clk), .rst(rst), .sel(sel), .sclk(sclk), .rise(rise)
  );

  uwr_wordmap #(
    .ADDR_BITS(ADDR_BITS), .DATA_BITS(DATA_BITS), .DEPTH(DEPTH),
    .NWORDS(NWORDS), .BASE_WORD(BASE_WORD)
  ) u_map (
    .clk(clk), .rst(rst), .addr(look_addr), .station_addr(station_addr),
    .hit(map_hit), .word(map_word)
  );

  uwr_fsm #(
    .OPC_BITS(OPC_BITS), .ADDR_BITS(ADDR_BITS), .DATA_BITS(DATA_BITS),
    .READ_OPC(READ_OPC)
  ) u_fsm (
    .clk(clk), .rst(rst), .sel(sel), .rise(rise), .din(din),
    .map_hit(map_hit), .map_word(map_word), .look_addr(look_addr),
    .dout_ld(dout_ld), .dout_val(dout_val), .din_clr(din_clr), .err(err)
  );

  assign data_out = dout;

  // R10
  dout_ro_chk: assert property (@(posedge clk) disable iff (rst)
    !dout_ld |=> $stable(data_out));
endmodule

// File: tb/uwire_eeprom_rd_tb.sv
module uwire_eeprom_rd_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_we = 1'b0;
  logic [3:0]  host_wdata = 4'h0;
  logic [47:0] station_addr = 48'h5AC3_1E97_64B8;
  logic [3:0]  host_rdata;
  logic        data_out;
  logic        err;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  uwire_eeprom_rd u_dut (
    .clk(clk), .rst(rst), .host_we(host_we), .host_wdata(host_wdata),
    .station_addr(station_addr), .host_rdata(host_rdata),
    .data_out(data_out), .err(err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // host register write: {dout(ignored), sel, sclk, din}
  task automatic hwrite(input logic sel, input logic sclk, input logic din,
                        input logic dw = 1'b0);
    @(negedge clk);
    host_we    = 1'b1;
    host_wdata = {dw, sel, sclk, din};
    @(negedge clk);
    host_we    = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic clk_bit(input logic d);
    hwrite(1'b1, 1'b0, d);
    hwrite(1'b1, 1'b1, d);
  endtask

  task automatic send_hdr(input logic [1:0] op, input logic [5:0] a, input int nab);
    clk_bit(1'b1);
    for (int i = 1; i >= 0; i--) clk_bit(op[i]);
    for (int i = 5; i > 5 - nab; i--) clk_bit(a[i]);
  endtask

  task automatic xfer(input logic [5:0] a, output logic [15:0] got, output logic din_after);
    send_hdr(2'b10, a, 6);
    din_after = host_rdata[0];
    for (int i = 15; i >= 0; i--) begin
      clk_bit(1'b0);
      got[i] = data_out;
    end
  endtask

  function automatic logic [15:0] exp_word(input logic [5:0] a);
    case (a)
      6'h0A:   return station_addr[47:32];
      6'h0B:   return station_addr[31:16];
      default: return station_addr[15:0];
    endcase
  endfunction

  task automatic t_reset();
    chk("R1 rdata", 32'(host_rdata), 0);
    chk("R1 data_out", 32'(data_out), 0);
    chk("R1 err", 32'(err), 0);
  endtask

  task automatic t_mapped_reads();
    logic [15:0] got;
    logic dinb;
    for (int k = 0; k < 3; k++) begin
      xfer(6'(10 + k), got, dinb);
      chk("R6 R8 word", 32'(got), 32'(exp_word(6'(10 + k))));
      chk("R9 din cleared", 32'(dinb), 0);
      chk("R8 no err", 32'(err), 0);
      hwrite(1'b0, 1'b0, 1'b0);
    end
  endtask

  task automatic t_prestart();
    logic [15:0] got;
    logic dinb;
    for (int i = 0; i < 3; i++) clk_bit(1'b0);
    chk("R4 idle dout", 32'(data_out), 0);
    xfer(6'h0B, got, dinb);
    chk("R4 after idle edges", 32'(got), 32'(exp_word(6'h0B)));
    hwrite(1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_bad_opcode();
    logic [1:0] ops [3] = '{2'b00, 2'b01, 2'b11};
    for (int k = 0; k < 3; k++) begin
      logic d0;
      d0 = data_out;
      send_hdr(ops[k], 6'h0A, 0);
      chk("R5 err set", 32'(err), 1);
      for (int i = 0; i < 4; i++) clk_bit(1'b0);
      chk("R5 err held", 32'(err), 1);
      chk("R5 dout unchanged", 32'(data_out), 32'(d0));
      hwrite(1'b0, 1'b0, 1'b0);
      chk("R3 err cleared", 32'(err), 0);
    end
  endtask

  task automatic t_bad_addr();
    logic [5:0] as [4] = '{6'h00, 6'h09, 6'h0D, 6'h3F};
    for (int k = 0; k < 4; k++) begin
      logic d0;
      d0 = data_out;
      send_hdr(2'b10, as[k], 6);
      chk("R7 err set", 32'(err), 1);
      for (int i = 0; i < 3; i++) clk_bit(1'b0);
      chk("R7 dout unchanged", 32'(data_out), 32'(d0));
      hwrite(1'b0, 1'b0, 1'b0);
    end
  endtask

  task automatic t_abort();
    logic [15:0] got;
    logic dinb;
    send_hdr(2'b10, 6'h0C, 3);
    hwrite(1'b0, 1'b0, 1'b1);
    chk("R3 din forced low", 32'(host_rdata[0]), 0);
    xfer(6'h0C, got, dinb);
    chk("R3 read after abort", 32'(got), 32'(exp_word(6'h0C)));
    hwrite(1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_no_rise_and_ro();
    logic d0;
    send_hdr(2'b10, 6'h0A, 6);
    clk_bit(1'b0);
    d0 = data_out;
    chk("R8 first bit", 32'(d0), 32'(station_addr[47]));
    hwrite(1'b1, 1'b1, 1'b1, ~d0);
    chk("R10 write keeps dout", 32'(host_rdata[3]), 32'(d0));
    chk("R2 repeated high no shift", 32'(data_out), 32'(d0));
    hwrite(1'b1, 1'b0, 1'b1, ~d0);
    hwrite(1'b1, 1'b0, 1'b0, ~d0);
    chk("R2 fall and din toggle", 32'(data_out), 32'(d0));
    hwrite(1'b1, 1'b1, 1'b0);
    chk("R2 next rise shifts", 32'(data_out), 32'(station_addr[46]));
    hwrite(1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_back_to_back();
    logic [15:0] got;
    logic dinb;
    logic d0;
    xfer(6'h0A, got, dinb);
    chk("R8 first word", 32'(got), 32'(exp_word(6'h0A)));
    d0 = data_out;
    clk_bit(1'b0);
    clk_bit(1'b0);
    chk("R8 idle after 16 bits", 32'(data_out), 32'(d0));
    xfer(6'h0C, got, dinb);
    chk("R8 second word no deselect", 32'(got), 32'(exp_word(6'h0C)));
    hwrite(1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired act=1 exp=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_mapped_reads();
    t_prestart();
    t_bad_opcode();
    t_bad_addr();
    t_abort();
    t_no_rise_and_ro();
    t_back_to_back();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule